// File: doc/BRIEF.md
# Programmable Skew Clock Output Controller

This block is the digital model of the output stage of a clock driver whose outputs can lead or lag a reference clock in fixed steps. It runs on a fast tap clock at sixteen times the nominal output frequency, so one tap tick is one skew time unit. A free-running phase counter provides the reference phase. Four banks each drive a pair of identical clock outputs. Each bank applies its own function to the shared phase: a delay or an advance in time units, a divide by two or four, or an inversion.

Every bank has a pair of decoded three-level selects: a high digit and a low digit, each coded 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH. The code 2'b11 reads as MID, the same as an undriven pin. A global stop request parks the outputs at a stop level. Bank 3 is exempt so that it can keep closing an external feedback loop. In the test mode the stop request acts only on banks whose select pair is LOW-LOW. An edge-select input chooses which edge of the reference the zero-skew phase follows. Stopping and restarting happen only when the output is already at its stop level, so no shortened high pulse appears.

Top module: `skew_clock_out`

## Requirements
- R1: While reset is active every output is low. After reset every bank runs at zero skew.
- R2: Reset release starts the reference phase P at 0, and P advances by one on each tap tick. The output seen after tick t reflects phase p = (P_{t-1} - B) mod 64, where B = 0 when edge_pos is high and B = 8 when it is low. A skew of s units gives a high output when ((p - s) mod 16) < 8.
- R3: For banks 1 and 2 the select index i = 3*high + low (LOW=0, MID=1, HIGH=2) gives a skew of i - 4 units.
- R4: For bank 3, index 0 divides by two (high when (p mod 32) < 16), index 8 divides by four (high when p < 32), and index 1 to 7 gives a skew of 2*(i - 4).
- R5: Bank 4 follows R4, except that index 8 gives the inverse of the zero-skew output.
- R6: A select digit of 2'b11 behaves as MID.
- R7: A new select code takes effect only at a tick where (p mod 16) = 0. Before that tick the old function stays in force.
- R8: With stop_req high and test_code not MID, banks 1, 2 and 4 sit at their stop level and bank 3 keeps running. When stop_req drops, all banks resume their programmed waveform.
- R9: The stop level is low. For bank 4 in the inverted mode it equals edge_pos.
- R10: With test_code MID and stop_req high, only banks whose select pair is LOW-LOW stop, bank 3 included. The other banks keep their programmed function.
- R11: A bank stops or restarts only on a tick where its waveform is already at the stop level. No high pulse is shorter than half a period.
- R12: The two outputs of a bank always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap clock, one tick per skew time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Synchronous output stop request |
| edge_pos | input | 1 | High: follow the rising reference edge; low: the falling edge |
| test_code | input | 2 | Decoded three-level test select (2'b01 or 2'b11 = MID) |
| sel_code | input | 16 | Four bits per bank, {high digit, low digit}, bank 1 in bits 3:0 |
| clk_out | output | 8 | Two outputs per bank, bank 1 in bits 1:0 |

## Verification
A wrong stored configuration shows as a misplaced edge on that bank's outputs within one sixteen-tick period of the next phase boundary. It is caught by comparing every tick of a 64-tick window against an arithmetic model of every code on every bank, for both edge polarities. A wrong enable state shows either as an output stuck at the wrong level or as a high pulse shorter than eight ticks. The bench watches high-run lengths while it toggles the stop request at assorted phases. The bench also checks the ticks just after a code change, where a configuration applied too early moves an edge before the boundary.

// File: rtl/skew_out_pkg.sv
package skew_out_pkg;

    localparam int unsigned TAP_PERIOD = 16;
    localparam int unsigned DLY_W      = $clog2(TAP_PERIOD);
    localparam int unsigned PH_W       = $clog2(TAP_PERIOD * 4);
    localparam int unsigned NBANK      = 4;
    localparam int unsigned SEL_W      = 4;
    localparam int unsigned FB_BANK    = 2;

    typedef enum logic [1:0] {
        MODE_SKEW = 2'd0,
        MODE_DIV2 = 2'd1,
        MODE_DIV4 = 2'd2,
        MODE_INV  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        KIND_FINE       = 2'd0,
        KIND_COARSE_DIV = 2'd1,
        KIND_COARSE_INV = 2'd2
    } kind_e;

    typedef struct packed {
        mode_e             mode;
        logic [DLY_W-1:0]  dly;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mode: MODE_SKEW, dly: '0};

    // Three-level digit: LOW=0, MID=1 (also 2'b11), HIGH=2
    function automatic int unsigned level_of(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 2;
        return 1;
    endfunction

    function automatic cfg_t decode_sel(input kind_e kind, input logic [SEL_W-1:0] sel);
        cfg_t        c;
        int unsigned idx;
        idx    = 3 * level_of(sel[3:2]) + level_of(sel[1:0]);
        c.mode = MODE_SKEW;
        if (kind == KIND_FINE) begin
            c.dly = DLY_W'(idx + TAP_PERIOD - 4);
        end else begin
            c.dly = DLY_W'(2 * idx + TAP_PERIOD - 8);
            if (idx == 0)
                c.mode = MODE_DIV2;
            else if (idx == 8)
                c.mode = (kind == KIND_COARSE_DIV) ? MODE_DIV4 : MODE_INV;
        end
        return c;
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen
    import skew_out_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_pos,
    output logic [PH_W-1:0] ref_ph
);
    localparam logic [PH_W-1:0] EDGE_SHIFT = PH_W'(TAP_PERIOD / 2);

    typedef struct packed {
        logic [PH_W-1:0] cnt;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        ref_ph   = st_q.cnt - (edge_pos ? '0 : EDGE_SHIFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/skew_bank.sv
module skew_bank
    import skew_out_pkg::*;
#(
    parameter kind_e KIND = KIND_FINE
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ref_ph,
    input  logic [SEL_W-1:0] sel,
    input  logic             dis_req,
    input  logic             edge_pos,
    output logic             bank_q
);
    typedef struct packed {
        cfg_t cfg;
        logic en;
        logic q;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic             boundary;
    logic             wave;
    logic             stop_lvl;
    logic [DLY_W-1:0] local_ph;

    always_comb begin
        st_d     = st_q;
        boundary = (ref_ph[DLY_W-1:0] == '0);
        if (boundary)
            st_d.cfg = decode_sel(KIND, sel);
        local_ph = ref_ph[DLY_W-1:0] - st_d.cfg.dly;
        case (st_d.cfg.mode)
            MODE_SKEW: wave = ~local_ph[DLY_W-1];
            MODE_DIV2: wave = ~ref_ph[DLY_W];
            MODE_DIV4: wave = ~ref_ph[DLY_W+1];
            MODE_INV:  wave = ref_ph[DLY_W-1];
            default:   wave = 1'b0;
        endcase
        stop_lvl = (st_d.cfg.mode == MODE_INV) & edge_pos;
        if (wave == stop_lvl)
            st_d.en = ~dis_req;
        st_d.q = st_d.en ? wave : stop_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET, en: 1'b1, q: 1'b0};
        else        st_q <= st_d;
    end

    assign bank_q = st_q.q;

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ph[DLY_W-1:0] != '0) |=> $stable(st_q.cfg));

    // R9
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && st_q.cfg.mode != MODE_INV) |-> !st_q.q);

    // R11
    clean_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.en) && st_q.cfg.mode != MODE_INV) |-> !st_q.q);

    // R8
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.en) |-> $past(dis_req));

    // R8
    run_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.en) |-> !$past(dis_req));

endmodule

// File: rtl/skew_clock_out.sv
module skew_clock_out
    import skew_out_pkg::*;
#(
    parameter int unsigned OUT_PER_BANK = 2
)(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            stop_req,
    input  logic                            edge_pos,
    input  logic [1:0]                      test_code,
    input  logic [NBANK*SEL_W-1:0]          sel_code,
    output logic [NBANK*OUT_PER_BANK-1:0]   clk_out
);
    logic [PH_W-1:0] ref_ph;
    logic            test_mid;

    assign test_mid = (test_code == 2'b01) || (test_code == 2'b11);

    skew_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_pos (edge_pos),
        .ref_ph   (ref_ph)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam kind_e K = (b < 2) ? KIND_FINE :
                              (b == FB_BANK) ? KIND_COARSE_DIV : KIND_COARSE_INV;
        localparam logic EXEMPT = (b == FB_BANK);

        logic [SEL_W-1:0] bank_sel;
        logic             is_ll;
        logic             dis;
        logic             bank_q;

        assign bank_sel = sel_code[b*SEL_W +: SEL_W];
        assign is_ll    = (bank_sel == '0);
        assign dis      = stop_req & (test_mid ? is_ll : ~EXEMPT);

        skew_bank #(.KIND(K)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_ph   (ref_ph),
            .sel      (bank_sel),
            .dis_req  (dis),
            .edge_pos (edge_pos),
            .bank_q   (bank_q)
        );

        assign clk_out[b*OUT_PER_BANK +: OUT_PER_BANK] = {OUT_PER_BANK{bank_q}};
    end

endmodule

// File: tb/skew_clock_out_test.sv
module skew_clock_out_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_req = 1'b0;
    logic        edge_pos = 1'b1;
    logic [1:0]  test_code = 2'b00;
    logic [15:0] sel_code = 16'h5555;
    logic [7:0]  clk_out;

    always #10 clk = ~clk;

    skew_clock_out uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .edge_pos(edge_pos),
        .test_code(test_code), .sel_code(sel_code), .clk_out(clk_out)
    );

    int tick;
    always @(posedge clk) begin
        if (!rst_n) tick <= 0;
        else        tick <= tick + 1;
    end

    int         vec = 0;
    int         bad = 0;
    logic [3:0] dis_exp = 4'b0000;

    function automatic int lvl(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b10) return 2;
        return 1;
    endfunction

    function automatic logic exp_wave(input int b, input logic [3:0] code, input int t, input logic pe);
        int p, idx, s;
        p   = ((t - 1 - (pe ? 0 : 8)) % 64 + 64) % 64;
        idx = 3 * lvl(code[3:2]) + lvl(code[1:0]);
        if (b < 2) begin
            s = idx - 4;
        end else begin
            if (idx == 0) return (p % 32) < 16;
            if (idx == 8) begin
                if (b == 2) return p < 32;
                return (p % 16) >= 8;
            end
            s = 2 * (idx - 4);
        end
        return (((p - s) % 16 + 16) % 16) < 8;
    endfunction

    function automatic logic exp_out(input int b, input int t);
        logic [3:0] code;
        code = sel_code[b*4 +: 4];
        if (dis_exp[b])
            return (b == 3 && code[3:2] == 2'b10 && code[1:0] == 2'b10) ? edge_pos : 1'b0;
        return exp_wave(b, code, t, edge_pos);
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_window(input string req, input int n);
        int bb[4];
        for (int b = 0; b < 4; b++) bb[b] = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                logic e;
                e = exp_out(b, tick);
                for (int o = 0; o < 2; o++) begin
                    if (clk_out[b*2+o] !== e && bb[b] == 0) begin
                        bb[b] = 1;
                        $display("FAIL %s (R12 pair) bank %0d out %0d tick %0d: actual %b expected %b",
                                 req, b + 1, o, tick, clk_out[b*2+o], e);
                    end
                end
            end
        end
        for (int b = 0; b < 4; b++) begin
            vec++;
            if (bb[b] != 0) bad++;
        end
    endtask

    // high-run monitor for R11
    logic   runt_on = 1'b0;
    int     runt_bad = 0;
    int     hi_len[8];
    logic   prev_q[8];
    always @(negedge clk) begin
        for (int o = 0; o < 8; o++) begin
            if (runt_on) begin
                if (prev_q[o] && !clk_out[o] && hi_len[o] < 8) begin
                    runt_bad++;
                    $display("FAIL R11 out %0d tick %0d: actual high run %0d expected >= 8",
                             o, tick, hi_len[o]);
                end
                hi_len[o] = clk_out[o] ? hi_len[o] + 1 : 0;
            end else begin
                hi_len[o] = 8;
            end
            prev_q[o] = clk_out[o];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        vec++;
        bad++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        settle(3);
        vec++;
        if (clk_out !== 8'h00) begin
            bad++;
            $display("FAIL R1 reset: actual %h expected 00", clk_out);
        end
        rst_n = 1'b1;
        run_window("R1 R2 default zero skew", 64);

        // R2..R6: every raw code on every bank, both edge polarities
        for (int pe = 1; pe >= 0; pe--) begin
            edge_pos = pe[0];
            for (int code = 0; code < 16; code++) begin
                sel_code = {4{code[3:0]}};
                settle(24);
                run_window("R2/R3/R4/R5/R6 sweep", 64);
            end
        end

        // R7: code applies at the phase boundary only
        edge_pos = 1'b1;
        sel_code = 16'h5555;
        settle(24);
        while (tick % 16 != 5) @(negedge clk);
        begin
            int   ok;
            logic applied;
            ok = 1;
            applied = 1'b0;
            sel_code[3:0] = 4'b1010;
            for (int k = 0; k < 40; k++) begin
                logic e;
                @(negedge clk);
                if ((tick - 1) % 16 == 0) applied = 1'b1;
                e = exp_wave(0, applied ? 4'b1010 : 4'b0101, tick, 1'b1);
                if (clk_out[0] !== e && ok == 1) begin
                    ok = 0;
                    $display("FAIL R7 tick %0d: actual %b expected %b", tick, clk_out[0], e);
                end
            end
            vec++;
            if (ok == 0) bad++;
        end

        // R8: global stop, bank 3 exempt (divide by two)
        sel_code = 16'h5055;
        stop_req = 1'b1;
        dis_exp  = 4'b1011;
        settle(24);
        run_window("R8 stopped", 64);
        stop_req = 1'b0;
        dis_exp  = 4'b0000;
        settle(24);
        run_window("R8 resumed", 64);

        // R9: inverted bank 4 stop level follows edge_pos
        sel_code = 16'hA555;
        stop_req = 1'b1;
        dis_exp  = 4'b1011;
        settle(24);
        run_window("R9 inverted stop high", 64);
        edge_pos = 1'b0;
        settle(24);
        run_window("R9 inverted stop low", 64);
        stop_req = 1'b0;
        dis_exp  = 4'b0000;
        edge_pos = 1'b1;

        // R10: test MID, only LL banks stop
        sel_code  = 16'h9050;
        test_code = 2'b01;
        stop_req  = 1'b1;
        dis_exp   = 4'b0101;
        settle(24);
        run_window("R10 test mid", 64);
        test_code = 2'b11;
        settle(24);
        run_window("R10 test mid alt code", 64);
        stop_req  = 1'b0;
        test_code = 2'b00;
        dis_exp   = 4'b0000;

        // R11: toggle stop at assorted phases, watch for runt pulses
        sel_code = 16'h5555;
        settle(24);
        runt_on = 1'b1;
        for (int r = 0; r < 3; r++) begin
            stop_req = 1'b1; settle(3 + r);
            stop_req = 1'b0; settle(13);
            stop_req = 1'b1; settle(21);
            stop_req = 1'b0; settle(5 + 2 * r);
            stop_req = 1'b1; settle(11);
            stop_req = 1'b0; settle(30);
        end
        runt_on = 1'b0;
        vec++;
        if (runt_bad != 0) bad++;
        run_window("R11 after toggling", 64);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule